// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with Refresh

This block sits between a simple single-word host port and an asynchronous DRAM that takes its address in two halves over shared pins. A request is latched with its write flag, address and write data. The block then walks the memory strobes through one complete access. It presents the upper address half as the row, and then the lower half as the column. On a read it captures the returned word. It acknowledges every access with a one-cycle done strobe. The host holds its request until it sees done.

A free-running interval timer raises a refresh request. The sequencer serves it with a refresh cycle in which CAS is lowered before RAS. A refresh that is pending when the sequencer is idle goes ahead of any host request. An access that has already started always runs to its end first. Every analog limit (precharge, RAS and CAS pulse widths, RAS-to-CAS delay, access time, refresh lead) is given as a whole number of clock cycles. At 100 MHz the default counts cover the nanosecond limits.

The states are as follows:
- IDLE waits for work.
- ROW holds RAS low with the row half on the pins.
- COL holds CAS low with the column half and captures read data on its last cycle.
- CAS_UP raises CAS while RAS stays low.
- PRECHARGE holds both strobes high.
- REF_CAS lowers CAS alone.
- REF_RAS holds both strobes low.

The transitions are as follows:
- IDLE→REF_CAS when a refresh is pending.
- IDLE→ROW on a request when no refresh is pending.
- ROW→COL, COL→CAS_UP, CAS_UP→PRECHARGE, REF_CAS→REF_RAS and REF_RAS→PRECHARGE, each taken when the cycle count of that state runs out.
- PRECHARGE→IDLE.

Top module: `dram_sequencer`

## Requirements
- R1: While reset is held, RAS, CAS and write-enable are all high (inactive), the data-bus enable is 0 and done is 0.
- R2: The row half (upper ADDR_W/2 bits of the request address) is on the DRAM address pins when RAS falls. The column half (lower ADDR_W/2 bits) is on the pins when CAS falls.
- R3: At the CAS fall of a write, write-enable is low (0) and the bus enable is 1 with the request's write data on the bus. On a read, write-enable stays high (1) and the bus enable stays 0.
- R4: On an access, CAS falls exactly T_RCD cycles after RAS falls (3 by default, never more than 9). CAS has been high at least one cycle when RAS falls.
- R5: RAS stays low at least T_RAS cycles (12) and high at least T_PRE cycles (9) between low periods. CAS stays low at least T_CAS cycles (3) on an access.
- R6: An access ends with CAS rising one cycle before RAS rises. CAS never falls a second time while RAS stays low in one access.
- R7: Read data is captured on the edge T_RAC cycles (12) after RAS fell, which is at least T_CAC cycles after CAS fell. The captured word holds on rd_data until the next read completes.
- R8: Done is high for exactly one cycle per access. With the sequencer idle and no refresh pending, done is seen 13 cycles after the request is first sampled.
- R9: A refresh lowers CAS while RAS is high. RAS falls T_CSR cycles (1) later. Both stay low for T_RAS cycles, then both rise together. RAS and CAS never fall on the same edge.
- R10: On an idle bus, refresh cycles start exactly every REF_CYCLES cycles. No two refresh starts are ever more than 750 cycles (7.5 µs) apart.
- R11: A refresh pending at the same edge as a new request is served first, and the request then completes 36 cycles after it was raised. An access in progress is never cut short by a pending refresh.
- R12: Every word written reads back unchanged, across refresh cycles that are interleaved with host traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until done |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Last captured read word |
| done | output | 1 | One-cycle completion strobe |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address |
| dram_dq_o | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for dram_dq_o |
| dram_dq_i | input | DATA_W | Data returned by the DRAM |

## Verification
The bench builds the sequencer with ADDR_W = 8 and DATA_W = 8, so the whole 256-word space is written and read back in one sweep. It sets REF_CYCLES = 300, which brings dozens of refresh cycles into the same run, many of them colliding with accesses at varied phases. All timing counts keep their defaults, so the strobe widths checked at the pins are the real 100 MHz figures. The memory model drives stale data until exactly 12 cycles after RAS falls, which makes a capture that comes one cycle early visible.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS_UP,
        ST_PRECHARGE,
        ST_REF_CAS,
        ST_REF_RAS
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_seq_delay.sv
`timescale 1ns/1ps
// Down-counter that times how long the sequencer stays in a state.
module dram_seq_delay #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/dram_seq_refresh_timer.sv
`timescale 1ns/1ps
// Free-running interval timer; raises a pending flag once per period.
module dram_seq_refresh_timer #(
    parameter int REF_CYCLES = 700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    localparam int TW = $clog2(REF_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(REF_CYCLES - 1);

    logic [TW-1:0] tick;
    logic          wrap;

    assign wrap = (tick == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= '0;
        end else if (wrap) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wrap) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/dram_seq_fsm.sv
`timescale 1ns/1ps
// Strobe sequencer: state register, next-state decode, Moore output decode.
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int D_ROW    = 3,
    parameter int D_COL    = 9,
    parameter int D_CASUP  = 1,
    parameter int D_PRE    = 9,
    parameter int D_REFCAS = 1,
    parameter int D_REFRAS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ref_pending,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             ref_ack,
    output logic             accept,
    output logic             capture,
    output logic             ras_n,
    output logic             cas_n,
    output logic             col_phase,
    output logic             we_phase
);

    seq_state_t state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending) begin
                    state_nx = ST_REF_CAS;
                end else if (req) begin
                    state_nx = ST_ROW;
                end
            end
            ST_ROW:       if (expired) state_nx = ST_COL;
            ST_COL:       if (expired) state_nx = ST_CAS_UP;
            ST_CAS_UP:    if (expired) state_nx = ST_PRECHARGE;
            ST_PRECHARGE: if (expired) state_nx = ST_IDLE;
            ST_REF_CAS:   if (expired) state_nx = ST_REF_RAS;
            ST_REF_RAS:   if (expired) state_nx = ST_PRECHARGE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Dwell counter reload on every state change
    assign load = (state_nx != state);

    always_comb begin
        load_val = '0;
        unique case (state_nx)
            ST_ROW:       load_val = CNT_W'(D_ROW - 1);
            ST_COL:       load_val = CNT_W'(D_COL - 1);
            ST_CAS_UP:    load_val = CNT_W'(D_CASUP - 1);
            ST_PRECHARGE: load_val = CNT_W'(D_PRE - 1);
            ST_REF_CAS:   load_val = CNT_W'(D_REFCAS - 1);
            ST_REF_RAS:   load_val = CNT_W'(D_REFRAS - 1);
            default:      load_val = '0;
        endcase
    end

    assign ref_ack = (state == ST_IDLE) && ref_pending;
    assign accept  = (state == ST_IDLE) && !ref_pending && req;
    assign capture = (state == ST_COL) && expired;

    // Outputs
    always_comb begin
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        col_phase = 1'b0;
        we_phase  = 1'b0;
        unique case (state)
            ST_ROW: begin
                ras_n    = 1'b0;
                we_phase = 1'b1;
            end
            ST_COL: begin
                ras_n     = 1'b0;
                cas_n     = 1'b0;
                col_phase = 1'b1;
                we_phase  = 1'b1;
            end
            ST_CAS_UP: begin
                ras_n = 1'b0;
            end
            ST_REF_CAS: begin
                cas_n = 1'b0;
            end
            ST_REF_RAS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: begin
                ras_n = 1'b1;
                cas_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dram_sequencer.sv
`timescale 1ns/1ps
module dram_sequencer
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 8,
    parameter int T_PRE      = 9,
    parameter int T_RAS      = 12,
    parameter int T_RCD      = 3,
    parameter int T_RCD_MAX  = 9,
    parameter int T_CAS      = 3,
    parameter int T_CAC      = 3,
    parameter int T_RAC      = 12,
    parameter int T_CSR      = 1,
    parameter int T_CHR      = 3,
    parameter int REF_CYCLES = 700
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  done,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    output logic                  dram_we_n,
    output logic [ADDR_W/2-1:0]   dram_addr,
    output logic [DATA_W-1:0]     dram_dq_o,
    output logic                  dram_dq_oe,
    input  logic [DATA_W-1:0]     dram_dq_i
);

    localparam int HALF     = ADDR_W / 2;
    // CAS-low dwell: long enough for CAS width, access times and RAS width
    localparam int D_COL    = max2(max2(T_CAS, T_CAC),
                                   max2(T_RAC - T_RCD, T_RAS - T_RCD - 1));
    localparam int D_REFRAS = max2(T_RAS, T_CHR);
    localparam int D_MAX    = max2(max2(max2(T_RCD, D_COL), max2(T_PRE, T_CSR)),
                                   max2(D_REFRAS, 2));
    localparam int CNT_W    = $clog2(D_MAX + 1);

    logic             ref_pending, ref_ack;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, capture, col_phase, we_phase;

    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;

    dram_seq_refresh_timer #(
        .REF_CYCLES (REF_CYCLES)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    dram_seq_delay #(
        .CNT_W (CNT_W)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dram_seq_fsm #(
        .CNT_W    (CNT_W),
        .D_ROW    (T_RCD),
        .D_COL    (D_COL),
        .D_CASUP  (1),
        .D_PRE    (T_PRE),
        .D_REFCAS (T_CSR),
        .D_REFRAS (D_REFRAS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .ref_pending (ref_pending),
        .expired     (tmr_expired),
        .load        (tmr_load),
        .load_val    (tmr_val),
        .ref_ack     (ref_ack),
        .accept      (accept),
        .capture     (capture),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .col_phase   (col_phase),
        .we_phase    (we_phase)
    );

    // Request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
        end
    end

    // Read capture and completion strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= capture;
            if (capture && !we_q) begin
                rd_data <= dram_dq_i;
            end
        end
    end

    assign dram_addr  = col_phase ? addr_q[HALF-1:0] : addr_q[ADDR_W-1:HALF];
    assign dram_we_n  = !(we_phase && we_q);
    assign dram_dq_oe = we_phase && we_q;
    assign dram_dq_o  = wdata_q;

endmodule

// File: rtl/dram_seq_checker.sv
`timescale 1ns/1ps
module dram_seq_checker #(
    parameter int T_PRE     = 9,
    parameter int T_RAS     = 12,
    parameter int T_RCD     = 3,
    parameter int T_RCD_MAX = 9,
    parameter int REF_LIMIT = 750
) (
    input logic clk,
    input logic rst_n,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic dram_dq_oe,
    input logic done
);

    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] ras_lo_cnt, ras_hi_cnt, ref_gap;
    logic        prev_ras, prev_cas, in_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= 16'(T_PRE);
            ref_gap    <= '0;
            prev_ras   <= 1'b1;
            prev_cas   <= 1'b1;
            in_ref     <= 1'b0;
        end else begin
            prev_ras <= dram_ras_n;
            prev_cas <= dram_cas_n;
            if (dram_ras_n) begin
                ras_lo_cnt <= '0;
                if (ras_hi_cnt != SAT) ras_hi_cnt <= ras_hi_cnt + 1'b1;
            end else begin
                ras_hi_cnt <= '0;
                if (ras_lo_cnt != SAT) ras_lo_cnt <= ras_lo_cnt + 1'b1;
            end
            if (prev_cas && !dram_cas_n && dram_ras_n) begin
                ref_gap <= '0;
                in_ref  <= 1'b1;
            end else begin
                if (ref_gap != SAT) ref_gap <= ref_gap + 1'b1;
                if (!prev_ras && dram_ras_n) in_ref <= 1'b0;
            end
        end
    end

    p_bus_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_ras_n));

    p_rcd_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (ras_lo_cnt >= 16'(T_RCD) && ras_lo_cnt <= 16'(T_RCD_MAX)));

    p_ras_low_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (ras_lo_cnt >= 16'(T_RAS)));

    p_precharge_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (ras_hi_cnt >= 16'(T_PRE)));

    p_cas_before_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dram_ras_n) && !in_ref) |-> dram_cas_n);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cas_leads_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> !$past(dram_cas_n));

    p_refresh_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gap <= 16'(REF_LIMIT));

endmodule

bind dram_sequencer dram_seq_checker #(
    .T_PRE     (T_PRE),
    .T_RAS     (T_RAS),
    .T_RCD     (T_RCD),
    .T_RCD_MAX (T_RCD_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_dq_oe (dram_dq_oe),
    .done       (done)
);

// File: tb/sim_dram_sequencer.sv
`timescale 1ns/1ps
module sim_dram_sequencer;

    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int HW    = AW / 2;
    localparam int REF   = 300;
    localparam int LIMIT = 750;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          done;
    logic          dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [HW-1:0] dram_addr;
    logic [DW-1:0] dram_dq_o;
    logic [DW-1:0] dram_dq_i = '0;

    always #5 clk = ~clk;

    dram_sequencer #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .REF_CYCLES (REF)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_data    (rd_data),
        .done       (done),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .dram_addr  (dram_addr),
        .dram_dq_o  (dram_dq_o),
        .dram_dq_oe (dram_dq_oe),
        .dram_dq_i  (dram_dq_i)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 29 + 7) ^ (a >> 3));
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural DRAM model (acts on falling clock edges)
    logic [DW-1:0] mem [0:(1<<AW)-1];
    bit            prev_ras = 1, prev_cas = 1;
    int            ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 100;
    bit            in_ref = 0, col_done = 0, amnesia = 0;
    logic [HW-1:0] row_q = '0, col_q = '0;
    int            last_ref = 0, ref_cnt = 0, last_acc = 0;

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit rf, rr, cf, cr;
            rf = prev_ras && !dram_ras_n;
            rr = !prev_ras && dram_ras_n;
            cf = prev_cas && !dram_cas_n;
            cr = !prev_cas && dram_cas_n;
            if (rf && cf) begin
                check(0, "R9 RAS and CAS fell together", 1, 0);
            end else if (rf && dram_cas_n) begin
                check(ras_hi >= 9, "R5 precharge before access", ras_hi, 9);
                check(cas_hi >= 1, "R4 CAS high before RAS fall", cas_hi, 1);
                row_q = dram_addr; in_ref = 0; col_done = 0; last_acc = cyc;
            end else if (rf) begin
                check(cas_lo >= 1, "R9 CAS lead before RAS", cas_lo, 1);
                check(ras_hi >= 9, "R5 precharge before refresh", ras_hi, 9);
                in_ref = 1;
            end else if (cf && dram_ras_n) begin
                check(cyc - last_ref <= LIMIT, "R10 refresh gap", cyc - last_ref, LIMIT);
                if (cyc - last_ref > LIMIT) amnesia = 1;
                last_ref = cyc; ref_cnt++;
            end else if (cf) begin
                check(ras_lo == 3, "R4 RAS-to-CAS delay", ras_lo, 3);
                check(!col_done, "R6 second CAS in one RAS", 1, 0);
                col_done = 1; col_q = dram_addr;
                if (!dram_we_n) begin
                    check(dram_dq_oe, "R3 write drives bus", dram_dq_oe, 1);
                    mem[{row_q, col_q}] = dram_dq_o;
                end else begin
                    check(!dram_dq_oe, "R3 read leaves bus", dram_dq_oe, 0);
                end
            end
            if (rr) begin
                check(ras_lo >= 12, "R5 RAS low width", ras_lo, 12);
                if (in_ref) check(dram_cas_n, "R9 both rise together", dram_cas_n, 1);
                else        check(dram_cas_n, "R6 CAS rises before RAS", dram_cas_n, 1);
                in_ref = 0;
            end
            if (cr && !dram_ras_n && !in_ref)
                check(cas_lo >= 3, "R5 CAS low width", cas_lo, 3);
            if (dram_ras_n) begin ras_hi = rr ? 1 : ras_hi + 1; ras_lo = 0; end
            else            begin ras_lo = rf ? 1 : ras_lo + 1; ras_hi = 0; end
            if (dram_cas_n) begin cas_hi = cr ? 1 : cas_hi + 1; cas_lo = 0; end
            else            begin cas_lo = cf ? 1 : cas_lo + 1; cas_hi = 0; end
            if (!dram_ras_n && !dram_cas_n && dram_we_n && !in_ref) begin
                if (ras_lo >= 12 && cas_lo >= 3 && !amnesia) dram_dq_i = mem[{row_q, col_q}];
                else                                        dram_dq_i = ~mem[{row_q, col_q}];
            end else begin
                dram_dq_i = 8'hA5;
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    // ---------------- host side
    task automatic access(input bit we, input int a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        req = 1; req_we = we; req_addr = AW'(a); req_wdata = wd; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 200);
        check(lat < 200, "R8 done arrives", lat, 13);
        rd = rd_data;
        req = 0;
        @(negedge clk);
        check(!done, "R8 done lasts one cycle", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        logic [DW-1:0] rd;
        int lat, n, r1, r2;
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        check(!dram_dq_oe && !done, "R1 bus off and done low in reset", {dram_dq_oe, done}, 0);
        rst_n = 1;
        @(negedge clk);

        // First access: exact latency and address split
        access(1, 8'h3C, 8'h9D, rd, lat);
        check(lat == 13, "R8 idle write latency", lat, 13);
        check(row_q == 4'h3, "R2 row half on RAS fall", row_q, 3);
        check(col_q == 4'hC, "R2 column half on CAS fall", col_q, 12);
        check(mem[8'h3C] == 8'h9D, "R3 write data stored", mem[8'h3C], 8'h9D);
        access(0, 8'h3C, 8'h00, rd, lat);
        check(rd == 8'h9D, "R7 read capture", rd, 8'h9D);
        check(lat == 13 || lat > 13, "R8 read latency bound", lat, 13);

        // Full sweep with refresh interleaved
        for (int a = 0; a < (1 << AW); a++) access(1, a, pat(a), rd, lat);
        for (int a = 0; a < (1 << AW); a++) begin
            access(0, a, 8'h00, rd, lat);
            check(rd == pat(a), "R12 sweep read-back", rd, pat(a));
        end
        // Overwrite a few, confirm the neighbours
        for (int a = 16; a < 32; a++) access(1, a, ~pat(a), rd, lat);
        for (int a = 15; a < 33; a++) begin
            access(0, a, 8'h00, rd, lat);
            check(rd == ((a >= 16 && a < 32) ? ~pat(a) : pat(a)), "R12 overwrite read-back",
                  rd, (a >= 16 && a < 32) ? ~pat(a) : pat(a));
        end
        check(rd_data == pat(32), "R7 rd_data holds after write-free idle", rd_data, pat(32));

        // Idle refresh cadence
        n = ref_cnt;
        wait (ref_cnt == n + 2);
        r1 = last_ref;
        wait (ref_cnt == n + 3);
        r2 = last_ref;
        check(r2 - r1 == REF, "R10 idle refresh period", r2 - r1, REF);

        // Request arrives on the same edge the refresh is taken
        while (cyc != r2 + REF - 1) @(negedge clk);
        req = 1; req_we = 0; req_addr = 8'd77; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 200);
        rd = rd_data;
        req = 0;
        check(last_ref == r2 + REF, "R11 refresh served first", last_ref, r2 + REF);
        check(last_acc == r2 + REF + 23, "R11 access follows refresh", last_acc, r2 + REF + 23);
        check(lat == 36, "R11 delayed request latency", lat, 36);
        check(rd == pat(77), "R12 read after refresh", rd, pat(77));
        repeat (30) @(negedge clk);
        summary();
    end

endmodule